// File: doc/BRIEF.md
# Split-Phase Bus Request Receiver

This block sits on the receive side of a shared processor bus whose lines are all active low. When a bus clock edge samples the transaction-start line low, the block arms itself for one request. The request then arrives in two halves on the same wires. The first half carries the byte address and a 5-bit request code. The second half reuses those lines for transaction-type attributes. Each half is latched by two source-synchronous strobes. The falling edge of a strobe takes the first half and its rising edge takes the second.

Each strobe owns one group of lines. Strobe 0 latches the request code and address bits 16..3. Strobe 1 latches address bits 35..17 and the two parity lines. Once both groups have completed their rising edge, each group's completion toggle is carried into the bus clock domain through a two-register synchronizer. The block then checks both parity lines for both halves and presents the whole request, in positive logic, with a one-cycle valid pulse. Parity faults are held in sticky per-line flags.

On the release of reset, a parameterized set of low address bits is captured as power-on configuration straps. These straps keep their value until the next reset.

Top module: `fsb_req_rx`

## Requirements
- R1: While reset is asserted, `rq_valid` is 0 and `rq_par_err` is 0.
- R2: `strap_cfg` holds the inverse of `addr_n[STRAP_W+2:3]` as sampled at the first bus clock edge after reset is released (bit 0 corresponds to address bit 3). It does not change again until the next reset, whatever the address lines do.
- R3: The first half is taken on the falling strobe edge. `rq_addr` shows the inverse of the address lines and `rq_kind` shows the inverse of the 5 request-code lines, both as they stood at that edge.
- R4: The second half is taken on the rising strobe edge. `rq_xattr` shows the inverse of the address lines and `rq_xkind` shows the inverse of the request-code lines, both as they stood at that edge.
- R5: Strobe 0 alone latches the request code and address bits 16..3. Strobe 1 alone latches address bits 35..17 and both parity lines. Values that a group's lines carry at the other group's edge are not captured.
- R6: A parity line's correct electrical level is high when an even number of the lines it covers are low. In the first half, line 0 covers address 35..24, and line 1 covers address 23..3 plus the request code. In the second half the two assignments swap. `rq_par_err[i]` is set when line i is wrong in either half.
- R7: The parity flags are sticky. A bus clock edge that samples `txn_start_n` low clears them. A request with a parity fault is still delivered with its data.
- R8: Each armed request gives `rq_valid` high for exactly one cycle, a few bus clocks after both strobes have risen. Strobe activity that no transaction start has armed delivers nothing.
- R9: A transaction start may be sampled on the same edge that delivers a request. In that case the flags show that request's parity faults (the set takes priority over the clear), and the next strobe pair is still armed and delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Asynchronous reset, active low |
| txn_start_n | input | 1 | Transaction start, active low, sampled on bus_clk |
| strb_n | input | 2 | Source-synchronous group strobes |
| addr_n | input | 33 | Address / attribute lines 35..3, active low |
| kind_n | input | 5 | Request-code lines, active low |
| par_n | input | 2 | Parity lines, active low |
| rq_valid | output | 1 | One-cycle request delivery pulse |
| rq_addr | output | 33 | First-half address, positive logic |
| rq_kind | output | 5 | First-half request code, positive logic |
| rq_xattr | output | 33 | Second-half attribute lines, positive logic |
| rq_xkind | output | 5 | Second-half request code, positive logic |
| rq_par_err | output | 2 | Sticky parity-fault flags, one per parity line |
| strap_cfg | output | 8 | Power-on straps |

## Verification
Two functions can land on the same bus clock edge. One is the arrival of a new transaction start, which clears the parity flags and arms the receiver. The other is the delivery of the previous request, which sets flags and disarms the receiver. The bench sends a request with a corrupted parity line and counts the synchronizer stages. It then drives the next transaction start so that it is sampled on exactly the delivery edge. The check passes only if the flags show the delivered request's fault right after that edge, and if a following strobe pair sent with no new start is still delivered.

// File: rtl/fsbrx_pkg.sv
`timescale 1ns/1ps
package fsbrx_pkg;

   localparam int unsigned NUM_GRP = 2;
   localparam int unsigned NUM_PAR = 2;

   typedef enum logic {
      SUB_A = 1'b0,
      SUB_B = 1'b1
   } subph_e;

   // parity line 0 covers the upper address slice in the first half,
   // line 1 covers it in the second half
   function automatic logic covers_high(subph_e sp, int unsigned line);
      return (sp == SUB_A) == (line == 0);
   endfunction

   // asserted parity must equal the odd-ness of the asserted covered lines
   function automatic logic line_bad(logic par_asserted, logic odd_asserted);
      return par_asserted ^ odd_asserted;
   endfunction

endpackage

// File: rtl/fsbrx_edge_capture.sv
`timescale 1ns/1ps
module fsbrx_edge_capture #(
   parameter int unsigned W = 19
) (
   input  logic         rst_n,
   input  logic         strb_n,
   input  logic [W-1:0] din_n,
   output logic [W-1:0] sub_a,
   output logic [W-1:0] sub_b,
   output logic         done_tgl
);

   // first half on the falling strobe edge
   always_ff @(negedge strb_n or negedge rst_n) begin
      if (!rst_n) sub_a <= '0;
      else        sub_a <= ~din_n;
   end

   // second half on the rising strobe edge; toggle marks completion
   always_ff @(posedge strb_n or negedge rst_n) begin
      if (!rst_n) begin
         sub_b    <= '0;
         done_tgl <= 1'b0;
      end else begin
         sub_b    <= ~din_n;
         done_tgl <= ~done_tgl;
      end
   end

endmodule

// File: rtl/fsbrx_handoff.sv
`timescale 1ns/1ps
module fsbrx_handoff #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/fsbrx_par_check.sv
`timescale 1ns/1ps
module fsbrx_par_check
   import fsbrx_pkg::*;
#(
   parameter int unsigned ADDR_HI   = 35,
   parameter int unsigned ADDR_LO   = 3,
   parameter int unsigned PAR_SPLIT = 24,
   parameter int unsigned KIND_W    = 5
) (
   input  logic [ADDR_HI:ADDR_LO] addr_a,
   input  logic [KIND_W-1:0]      kind_a,
   input  logic [NUM_PAR-1:0]     par_a,
   input  logic [ADDR_HI:ADDR_LO] addr_b,
   input  logic [KIND_W-1:0]      kind_b,
   input  logic [NUM_PAR-1:0]     par_b,
   output logic [NUM_PAR-1:0]     err
);

   logic odd_hi_a, odd_lo_a, odd_hi_b, odd_lo_b;

   assign odd_hi_a = ^addr_a[ADDR_HI:PAR_SPLIT];
   assign odd_lo_a = ^{addr_a[PAR_SPLIT-1:ADDR_LO], kind_a};
   assign odd_hi_b = ^addr_b[ADDR_HI:PAR_SPLIT];
   assign odd_lo_b = ^{addr_b[PAR_SPLIT-1:ADDR_LO], kind_b};

   for (genvar l = 0; l < NUM_PAR; l++) begin : g_line
      localparam bit A_HI = covers_high(SUB_A, l);
      localparam bit B_HI = covers_high(SUB_B, l);
      logic odd_a, odd_b;
      assign odd_a  = A_HI ? odd_hi_a : odd_lo_a;
      assign odd_b  = B_HI ? odd_hi_b : odd_lo_b;
      assign err[l] = line_bad(par_a[l], odd_a) | line_bad(par_b[l], odd_b);
   end

endmodule

// File: rtl/fsb_req_rx.sv
`timescale 1ns/1ps
module fsb_req_rx
   import fsbrx_pkg::*;
#(
   parameter int unsigned ADDR_HI     = 35,
   parameter int unsigned ADDR_LO     = 3,
   parameter int unsigned GRP_SPLIT   = 17,
   parameter int unsigned PAR_SPLIT   = 24,
   parameter int unsigned KIND_W      = 5,
   parameter int unsigned STRAP_W     = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                     bus_clk,
   input  logic                     bus_rst_n,
   input  logic                     txn_start_n,
   input  logic [NUM_GRP-1:0]       strb_n,
   input  logic [ADDR_HI:ADDR_LO]   addr_n,
   input  logic [KIND_W-1:0]        kind_n,
   input  logic [NUM_PAR-1:0]       par_n,
   output logic                     rq_valid,
   output logic [ADDR_HI:ADDR_LO]   rq_addr,
   output logic [KIND_W-1:0]        rq_kind,
   output logic [ADDR_HI:ADDR_LO]   rq_xattr,
   output logic [KIND_W-1:0]        rq_xkind,
   output logic [NUM_PAR-1:0]       rq_par_err,
   output logic [STRAP_W-1:0]       strap_cfg
);

   localparam int unsigned AW   = ADDR_HI - ADDR_LO + 1;
   localparam int unsigned LO_W = GRP_SPLIT - ADDR_LO;
   localparam int unsigned HI_W = ADDR_HI - GRP_SPLIT + 1;
   localparam int unsigned G0_W = LO_W + KIND_W;
   localparam int unsigned G1_W = HI_W + NUM_PAR;

   initial begin
      if (GRP_SPLIT <= ADDR_LO || GRP_SPLIT > ADDR_HI)
         $fatal(1, "fsb_req_rx: GRP_SPLIT out of range");
      if (PAR_SPLIT <= ADDR_LO || PAR_SPLIT > ADDR_HI)
         $fatal(1, "fsb_req_rx: PAR_SPLIT out of range");
      if (STRAP_W == 0 || STRAP_W > AW)
         $fatal(1, "fsb_req_rx: STRAP_W out of range");
      if (SYNC_STAGES < 2)
         $fatal(1, "fsb_req_rx: SYNC_STAGES below 2");
      if (KIND_W == 0)
         $fatal(1, "fsb_req_rx: KIND_W is zero");
   end

   // ---------------- strobe-domain capture ----------------
   logic [G0_W-1:0]    g0_a, g0_b;
   logic [G1_W-1:0]    g1_a, g1_b;
   logic [NUM_GRP-1:0] tgl_raw, tgl_sync;

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      if (g == 0) begin : g_low
         fsbrx_edge_capture #(.W(G0_W)) u_cap (
            .rst_n    (bus_rst_n),
            .strb_n   (strb_n[g]),
            .din_n    ({addr_n[GRP_SPLIT-1:ADDR_LO], kind_n}),
            .sub_a    (g0_a),
            .sub_b    (g0_b),
            .done_tgl (tgl_raw[g])
         );
      end else begin : g_high
         fsbrx_edge_capture #(.W(G1_W)) u_cap (
            .rst_n    (bus_rst_n),
            .strb_n   (strb_n[g]),
            .din_n    ({addr_n[ADDR_HI:GRP_SPLIT], par_n}),
            .sub_a    (g1_a),
            .sub_b    (g1_b),
            .done_tgl (tgl_raw[g])
         );
      end
      fsbrx_handoff #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (bus_clk),
         .rst_n (bus_rst_n),
         .d     (tgl_raw[g]),
         .q     (tgl_sync[g])
      );
   end

   // ---------------- reassembly ----------------
   logic [ADDR_HI:ADDR_LO] addr_a, addr_b;
   logic [KIND_W-1:0]      kind_a, kind_b;
   logic [NUM_PAR-1:0]     par_a, par_b, new_err;

   assign addr_a = {g1_a[G1_W-1:NUM_PAR], g0_a[G0_W-1:KIND_W]};
   assign addr_b = {g1_b[G1_W-1:NUM_PAR], g0_b[G0_W-1:KIND_W]};
   assign kind_a = g0_a[KIND_W-1:0];
   assign kind_b = g0_b[KIND_W-1:0];
   assign par_a  = g1_a[NUM_PAR-1:0];
   assign par_b  = g1_b[NUM_PAR-1:0];

   fsbrx_par_check #(
      .ADDR_HI   (ADDR_HI),
      .ADDR_LO   (ADDR_LO),
      .PAR_SPLIT (PAR_SPLIT),
      .KIND_W    (KIND_W)
   ) u_par (
      .addr_a (addr_a),
      .kind_a (kind_a),
      .par_a  (par_a),
      .addr_b (addr_b),
      .kind_b (kind_b),
      .par_b  (par_b),
      .err    (new_err)
   );

   // ---------------- bus-clock domain ----------------
   logic [NUM_GRP-1:0] tgl_seen;
   logic               all_ready, armed, deliver;

   assign all_ready = &(tgl_sync ^ tgl_seen);
   assign deliver   = all_ready & armed;

   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) begin
         tgl_seen   <= '0;
         armed      <= 1'b0;
         rq_valid   <= 1'b0;
         rq_par_err <= '0;
         rq_addr    <= '0;
         rq_kind    <= '0;
         rq_xattr   <= '0;
         rq_xkind   <= '0;
      end else begin
         rq_valid <= deliver;
         if (all_ready) tgl_seen <= tgl_sync;
         // a start sampled on a delivery edge keeps the receiver armed
         armed <= !txn_start_n | (armed & ~all_ready);
         // clear on start, then merge in faults of the request delivered now
         rq_par_err <= (txn_start_n ? rq_par_err : '0) | (deliver ? new_err : '0);
         if (deliver) begin
            rq_addr  <= addr_a;
            rq_kind  <= kind_a;
            rq_xattr <= addr_b;
            rq_xkind <= kind_b;
         end
      end
   end

   // ---------------- power-on straps ----------------
   logic strap_open;

   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) strap_open <= 1'b1;
      else            strap_open <= 1'b0;
   end

   always_ff @(posedge bus_clk) begin
      if (strap_open) strap_cfg <= ~addr_n[ADDR_LO +: STRAP_W];
   end

endmodule

// File: rtl/fsb_req_rx_chk.sv
`timescale 1ns/1ps
module fsb_req_rx_chk #(
   parameter int unsigned STRAP_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               txn_start_n,
   input logic               rq_valid,
   input logic [1:0]         rq_par_err,
   input logic [STRAP_W-1:0] strap_cfg
);

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (!rq_valid && rq_par_err == 2'b00)
            else $error("R1 outputs active in reset");
      end
   end

   p_strap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2)) |-> $stable(strap_cfg));

   p_err_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((rq_par_err & ~$past(rq_par_err)) != 2'b00) |-> rq_valid);

   p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !txn_start_n |=> (rq_valid || rq_par_err == 2'b00));

   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      txn_start_n |=> ((rq_par_err & $past(rq_par_err)) == $past(rq_par_err)));

   p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rq_valid |=> !rq_valid);

endmodule

bind fsb_req_rx fsb_req_rx_chk #(.STRAP_W(STRAP_W)) u_chk (
   .clk         (bus_clk),
   .rst_n       (bus_rst_n),
   .txn_start_n (txn_start_n),
   .rq_valid    (rq_valid),
   .rq_par_err  (rq_par_err),
   .strap_cfg   (strap_cfg)
);

// File: tb/fsb_req_rx_tb_top.sv
`timescale 1ns/1ps
module fsb_req_rx_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_n = 1'b1;
   logic [1:0]  strb_n = 2'b11;
   logic [35:3] addr_n = '1;
   logic [4:0]  kind_n = '1;
   logic [1:0]  par_n = 2'b11;

   logic        rq_valid;
   logic [35:3] rq_addr, rq_xattr;
   logic [4:0]  rq_kind, rq_xkind;
   logic [1:0]  rq_par_err;
   logic [7:0]  strap_cfg;

   always #2.5 clk = ~clk;

   fsb_req_rx dut_i (
      .bus_clk     (clk),
      .bus_rst_n   (rst_n),
      .txn_start_n (start_n),
      .strb_n      (strb_n),
      .addr_n      (addr_n),
      .kind_n      (kind_n),
      .par_n       (par_n),
      .rq_valid    (rq_valid),
      .rq_addr     (rq_addr),
      .rq_kind     (rq_kind),
      .rq_xattr    (rq_xattr),
      .rq_xkind    (rq_xkind),
      .rq_par_err  (rq_par_err),
      .strap_cfg   (strap_cfg)
   );

   typedef struct packed {
      logic [35:3] aa;
      logic [4:0]  ka;
      logic [35:3] ab;
      logic [4:0]  kb;
      logic [1:0]  err;
   } item_t;

   item_t q[$];
   int    n_chk = 0;
   int    n_fail = 0;
   int    n_valid = 0;
   int    n_push = 0;
   bit    armed_m = 1'b0;
   logic [1:0] err_m = 2'b00;
   bit    done = 1'b0;

   task automatic chk(input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // electrical parity lines: high when an even number of covered lines are low
   function automatic logic [1:0] par_lines(input logic [35:3] a, input logic [4:0] k,
                                            input bit second);
      int hi_lows, lo_lows;
      logic p_hi, p_lo;
      hi_lows = $countones(a[35:24]);
      lo_lows = $countones(a[23:3]) + $countones(k);
      p_hi = (hi_lows % 2) == 0;
      p_lo = (lo_lows % 2) == 0;
      return second ? {p_hi, p_lo} : {p_lo, p_hi};
   endfunction

   task automatic drive_half(input logic [35:3] a, input logic [4:0] k,
                             input logic [1:0] pn, input bit stagger, input logic lvl);
      logic [35:3] an;
      an = ~a;
      if (!stagger) begin
         addr_n = an;
         kind_n = ~k;
         par_n  = pn;
         #1 strb_n = {lvl, lvl};
      end else begin
         // each group's lines carry junk at the other group's edge (R5)
         addr_n[16:3]  = an[16:3];
         kind_n        = ~k;
         addr_n[35:17] = a[35:17];
         par_n         = ~pn;
         #1 strb_n[0]  = lvl;
         #1;
         addr_n[16:3]  = a[16:3];
         kind_n        = k;
         addr_n[35:17] = an[35:17];
         par_n         = pn;
         #1 strb_n[1]  = lvl;
      end
   endtask

   task automatic send(input logic [35:3] aa, input logic [4:0] ka,
                       input logic [35:3] ab, input logic [4:0] kb,
                       input logic [1:0] fa, input logic [1:0] fb,
                       input bit use_start, input bit stagger, input bit overlap);
      item_t it;
      if (use_start) begin
         @(posedge clk); #1 start_n = 1'b0;
         @(posedge clk); #1 start_n = 1'b1;
         armed_m = 1'b1;
         err_m   = 2'b00;
         chk("R7", "flags cleared by start", rq_par_err, 2'b00);
      end
      @(posedge clk); #1;
      drive_half(aa, ka, par_lines(aa, ka, 1'b0) ^ fa, stagger, 1'b0);
      @(posedge clk); #1;
      drive_half(ab, kb, par_lines(ab, kb, 1'b1) ^ fb, stagger, 1'b1);
      if (armed_m) begin
         err_m  = err_m | fa | fb;
         it.aa  = aa; it.ka = ka; it.ab = ab; it.kb = kb; it.err = err_m;
         q.push_back(it);
         n_push++;
         armed_m = 1'b0;
      end
      if (overlap) begin
         // two synchronizer stages, then the delivery edge
         @(posedge clk);
         @(posedge clk); #1 start_n = 1'b0;
         @(posedge clk); #1 start_n = 1'b1;
         armed_m = 1'b1;
         chk("R9", "flags after start on delivery edge", rq_par_err, err_m);
      end
      repeat (6) @(posedge clk);
   endtask

   // scoreboard monitor
   initial begin
      bit prev_v;
      item_t e;
      prev_v = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (rq_valid) begin
               n_valid++;
               if (prev_v) chk("R8", "valid longer than one cycle", 1, 0);
               if (q.size() == 0) begin
                  chk("R8", "unexpected delivery", 1, 0);
               end else begin
                  e = q.pop_front();
                  chk("R3", "rq_addr",  rq_addr,  e.aa);
                  chk("R3", "rq_kind",  rq_kind,  e.ka);
                  chk("R4", "rq_xattr", rq_xattr, e.ab);
                  chk("R4", "rq_xkind", rq_xkind, e.kb);
                  chk("R6", "rq_par_err", rq_par_err, e.err);
               end
            end
            prev_v = rq_valid;
         end
      end
   end

   initial begin
      #500000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int v0;
      addr_n[10:3] = ~8'hA5;
      repeat (3) @(negedge clk);
      chk("R1", "valid in reset", rq_valid, 1'b0);
      chk("R1", "flags in reset", rq_par_err, 2'b00);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R2", "strap after release", strap_cfg, 8'hA5);
      addr_n[10:3] = ~8'h3C;
      repeat (3) @(negedge clk);
      chk("R2", "strap holds", strap_cfg, 8'hA5);

      // R3 R4 plain transfers with distinct patterns
      send(33'h1_2345_6789, 5'h0B, 33'h0_00F0_0F00, 5'h14, 2'b00, 2'b00, 1, 0, 0);
      send('1, 5'h1F, '0, 5'h00, 2'b00, 2'b00, 1, 0, 0);
      send(33'h0_AAAA_5555, 5'h15, 33'h1_5555_AAAA, 5'h0A, 2'b00, 2'b00, 1, 0, 0);
      // R5 staggered group strobes with junk on the other group
      send(33'h1_C3C3_3C3C, 5'h06, 33'h0_1234_FEDC, 5'h19, 2'b00, 2'b00, 1, 1, 0);
      // R6 faults on each line and half
      send(33'h0_0000_0001, 5'h01, 33'h0_0100_0000, 5'h02, 2'b01, 2'b00, 1, 0, 0);
      send(33'h1_0000_0000, 5'h10, 33'h0_0000_0080, 5'h04, 2'b00, 2'b10, 1, 0, 0);
      send(33'h0_7777_1111, 5'h03, 33'h1_8888_2222, 5'h1C, 2'b10, 2'b01, 1, 1, 0);
      // R7 flags remain without a new start
      repeat (10) @(posedge clk);
      #1 chk("R7", "flags sticky while idle", rq_par_err, 2'b11);
      // R8 strobes without a start deliver nothing
      v0 = n_valid;
      send(33'h0_0F0F_0F0F, 5'h07, 33'h0_F0F0_F0F0, 5'h18, 2'b00, 2'b00, 0, 0, 0);
      chk("R8", "no delivery when unarmed", n_valid, v0);
      chk("R7", "flags kept over unarmed strobes", rq_par_err, 2'b11);
      // R9 start on the delivery edge, then a strobe pair with no new start
      send(33'h1_0101_0101, 5'h11, 33'h0_2020_2020, 5'h05, 2'b01, 2'b00, 1, 0, 1);
      send(33'h0_3333_CCCC, 5'h0E, 33'h1_CCCC_3333, 5'h13, 2'b00, 2'b00, 0, 0, 0);
      chk("R9", "request after overlapped start delivered", n_valid, v0 + 2);
      // fresh start clears, clean request
      send(33'h1_FFFF_0000, 5'h1A, 33'h0_0000_FFFF, 5'h09, 2'b00, 2'b00, 1, 0, 0);
      chk("R7", "flags after clean request", rq_par_err, 2'b00);
      chk("R2", "strap unchanged after traffic", strap_cfg, 8'hA5);

      repeat (10) @(posedge clk);
      chk("R8", "queue drained", q.size(), 0);
      chk("R8", "deliveries match requests", n_valid, n_push);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule